// File: doc/BRIEF.md
# Per-Step Timing Failure Rate Histogram

This block characterises how one registered path bit degrades as its test clock is raised. Outside logic drives the path and steps the clock frequency. For every frequency step it opens a measurement window of a programmable number of cycles. In each cycle of that window it compares the bit captured by the path's sample register with a reference. The reference is the path's own pre-register output, delayed by one clock inside the block. At speeds the path can meet, the two agree. Once the clock outruns the path, the sample register starts to catch stale values and mismatches appear.

Every mismatch in a window is counted in a counter that saturates instead of wrapping. When the window closes, the count goes into a histogram slot addressed by the step number, and the step number advances. A registered read port returns any slot afterwards.

The block also latches the first step whose count exceeds a programmable threshold, so the onset of failure is known without a scan of the histogram. The stimulus does not have to repeat from one step to the next, because each comparison is made against the path's own fault-free value. A sweep-clear pulse restarts the step numbering for a new sweep.

Top module: `fail_rate_hist`

## Requirements
- R1: After reset the block is idle. busy, step_done, sweep_full and first_fail_vld are 0, and cur_step is 0.
- R2: A mismatch is a difference between path_smp and the value ref_pre had one clock earlier. The error count is cleared when a step is accepted. It counts mismatches on exactly win_len consecutive clock edges, starting with the edge after the accepting edge, and it does not change outside the window.
- R3: The error count saturates at 2^CNT_W-1 and stays there for the rest of the window.
- R4: busy drops and step_done goes high for exactly one cycle on the edge after the last compared edge. During that cycle last_count holds the step's final count and cur_step still holds the step's index.
- R5: At the end of the step_done cycle, the final count is written into histogram slot cur_step and cur_step increments by one. rd_data returns slot rd_addr one clock after rd_addr is applied.
- R6: step_start is ignored while busy is high, during a step_done cycle, while sweep_full is high, and when win_len is 0.
- R7: first_fail_vld rises at the first step whose final count is strictly greater than threshold, and first_fail_idx holds that step's index. A count equal to threshold does not trigger it, and later steps leave both outputs unchanged.
- R8: sweep_clr sets cur_step to 0, clears first_fail_vld and abandons an open window without writing it or pulsing step_done. It leaves the histogram contents intact and takes priority over step_start.
- R9: sweep_full is high when cur_step equals STEPS. Once it is high, no further step can be started until sweep_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_clr | input | 1 | Restart step numbering and abandon any window |
| step_start | input | 1 | Pulse to open a window for the current step |
| win_len | input | WIN_W | Window length in cycles |
| threshold | input | CNT_W | Count above which a step counts as failing |
| ref_pre | input | 1 | Path output taken before its sample register |
| path_smp | input | 1 | Path output as captured by its sample register |
| busy | output | 1 | Window open |
| step_done | output | 1 | One-cycle pulse when a window has closed |
| cur_step | output | $clog2(STEPS)+1 | Index of the step being measured |
| sweep_full | output | 1 | All histogram slots of this sweep are written |
| last_count | output | CNT_W | Running or final error count |
| first_fail_vld | output | 1 | A failing step has been seen |
| first_fail_idx | output | $clog2(STEPS) | Index of the first failing step |
| rd_addr | input | $clog2(STEPS) | Histogram read address |
| rd_data | output | CNT_W | Histogram slot at rd_addr, one clock later |

## Verification
The bench builds the block with STEPS=8, CNT_W=6 and WIN_W=10. With these values the counter saturates at 63, so a 100-cycle window of constant mismatches pushes it well past its limit. Eight slots also let a short run fill the whole sweep, which exercises the full flag, the refusal of further steps and a read-back of every slot. A threshold of 12 lets one step land exactly on it and a later step cross it, which checks the strict comparison and the one-time capture of the failing step.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } step_state_e;

    // Controller decisions handed to the datapath each cycle
    typedef struct packed {
        logic open_win;   // step accepted this cycle
        logic run;        // compare edge
        logic done;       // window just closed
    } step_ctl_t;

    function automatic logic is_mismatch(input logic ref_bit, input logic smp_bit);
        return ref_bit ^ smp_bit;
    endfunction

endpackage

// File: rtl/fr_step_ctrl.sv
module fr_step_ctrl
    import fr_pkg::*;
#(
    parameter int STEPS = 64,
    parameter int WIN_W = 20,
    localparam int IDX_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sweep_clr,
    input  logic             step_start,
    input  logic [WIN_W-1:0] win_len,
    output step_ctl_t        ctl,
    output logic [IDX_W:0]   step_idx,
    output logic             full
);

    localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(STEPS);

    step_state_e      state;
    logic [WIN_W-1:0] remain;
    logic             accept;

    assign full   = (step_idx == LAST_IDX);
    assign accept = (state == ST_IDLE) && step_start && !sweep_clr
                    && !full && (win_len != '0);

    always_comb begin
        ctl.open_win = accept;
        ctl.run      = (state == ST_RUN);
        ctl.done     = (state == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            remain   <= '0;
            step_idx <= '0;
        end else if (sweep_clr) begin
            state    <= ST_IDLE;
            remain   <= '0;
            step_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state  <= ST_RUN;
                    remain <= win_len;
                end
                ST_RUN: begin
                    remain <= remain - 1'b1;
                    if (remain == WIN_W'(1)) state <= ST_DONE;
                end
                ST_DONE: begin
                    state    <= ST_IDLE;
                    step_idx <= step_idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: a window never closes on a full sweep
    assert_no_done_when_full_R9: assert property (@(posedge clk) disable iff (rst)
        ctl.done |-> !full);

    // R6: a step request is never taken while one is running
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.run || ctl.done) |-> !ctl.open_win);

endmodule

// File: rtl/fr_err_acc.sv
module fr_err_acc
    import fr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_ctl_t        ctl,
    input  logic             ref_pre,
    input  logic             path_smp,
    output logic [CNT_W-1:0] err_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic ref_q;
    logic miss;

    assign miss = is_mismatch(ref_q, path_smp);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= 1'b0;
            err_cnt <= '0;
        end else begin
            ref_q <= ref_pre;
            if (ctl.open_win)
                err_cnt <= '0;
            else if (ctl.run && miss && (err_cnt != CNT_MAX))
                err_cnt <= err_cnt + 1'b1;
        end
    end

    // R3: a saturated count stays put while the window runs
    assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && err_cnt == CNT_MAX) |=> err_cnt == CNT_MAX);

    // R2: outside a window, and not at acceptance, the count is frozen
    assert_frozen_outside_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !ctl.open_win) |=> $stable(err_cnt));

    // R2: at most one increment per compared edge
    assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.run |=> (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1));

endmodule

// File: rtl/fr_hist_store.sv
module fr_hist_store #(
    parameter int STEPS = 64,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sweep_clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [CNT_W-1:0] threshold,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             ff_vld,
    output logic [IDX_W-1:0] ff_idx
);

    logic [CNT_W-1:0] slots [STEPS];

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= slots[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst || sweep_clr) begin
            ff_vld <= 1'b0;
            ff_idx <= '0;
        end else if (wr_en && !ff_vld && (wr_cnt > threshold)) begin
            ff_vld <= 1'b1;
            ff_idx <= wr_idx;
        end
    end

    // R7: once captured, the first failing step is held until a sweep clear
    assert_ff_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ff_vld && !sweep_clr) |=> ff_vld && $stable(ff_idx));

endmodule

// File: rtl/fail_rate_hist.sv
module fail_rate_hist
    import fr_pkg::*;
#(
    parameter int STEPS = 64,
    parameter int CNT_W = 16,
    parameter int WIN_W = 20,
    localparam int IDX_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sweep_clr,
    input  logic             step_start,
    input  logic [WIN_W-1:0] win_len,
    input  logic [CNT_W-1:0] threshold,
    input  logic             ref_pre,
    input  logic             path_smp,
    output logic             busy,
    output logic             step_done,
    output logic [IDX_W:0]   cur_step,
    output logic             sweep_full,
    output logic [CNT_W-1:0] last_count,
    output logic             first_fail_vld,
    output logic [IDX_W-1:0] first_fail_idx,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_data
);

    step_ctl_t ctl;
    logic      wr_en;

    fr_step_ctrl #(.STEPS(STEPS), .WIN_W(WIN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sweep_clr  (sweep_clr),
        .step_start (step_start),
        .win_len    (win_len),
        .ctl        (ctl),
        .step_idx   (cur_step),
        .full       (sweep_full)
    );

    fr_err_acc #(.CNT_W(CNT_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .ref_pre  (ref_pre),
        .path_smp (path_smp),
        .err_cnt  (last_count)
    );

    assign wr_en = ctl.done && !sweep_clr;

    fr_hist_store #(.STEPS(STEPS), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .sweep_clr (sweep_clr),
        .wr_en     (wr_en),
        .wr_idx    (cur_step[IDX_W-1:0]),
        .wr_cnt    (last_count),
        .threshold (threshold),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ff_vld    (first_fail_vld),
        .ff_idx    (first_fail_idx)
    );

    assign busy      = ctl.run;
    assign step_done = ctl.done;

    // R4: window close is a single-cycle pulse, never overlapping busy
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        step_done |=> !step_done && !busy);

    // R5: each written step advances the step index by one
    assert_idx_advance_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cur_step == $past(cur_step) + 1'b1);

    // R8: a sweep clear returns the step index to zero
    assert_clr_zero_R8: assert property (@(posedge clk) disable iff (rst)
        sweep_clr |=> cur_step == '0 && !busy && !step_done);

endmodule

// File: tb/fail_rate_hist_tb.sv
`timescale 1ns/1ps
module fail_rate_hist_tb;

    localparam int STEPS = 8;
    localparam int CNT_W = 6;
    localparam int WIN_W = 10;
    localparam int IDX_W = $clog2(STEPS);
    localparam int MAXC  = (1 << CNT_W) - 1;
    localparam int THR   = 12;

    logic             clk = 1'b0;
    logic             rst;
    logic             sweep_clr, step_start, ref_pre, path_smp;
    logic [WIN_W-1:0] win_len;
    logic [CNT_W-1:0] threshold;
    logic             busy, step_done, sweep_full, first_fail_vld;
    logic [IDX_W:0]   cur_step;
    logic [CNT_W-1:0] last_count, rd_data;
    logic [IDX_W-1:0] first_fail_idx, rd_addr;

    int checks = 0;
    int failures = 0;
    int exp_hist [STEPS];
    int exp_q [$];
    int idx_q [$];

    always #2.5 clk = ~clk;

    fail_rate_hist #(.STEPS(STEPS), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_dut (
        .clk(clk), .rst(rst), .sweep_clr(sweep_clr), .step_start(step_start),
        .win_len(win_len), .threshold(threshold), .ref_pre(ref_pre),
        .path_smp(path_smp), .busy(busy), .step_done(step_done),
        .cur_step(cur_step), .sweep_full(sweep_full), .last_count(last_count),
        .first_fail_vld(first_fail_vld), .first_fail_idx(first_fail_idx),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of path stimulus; flip=1 makes the sample disagree with the reference
    task automatic drive_cycle(input bit flip);
        logic prev;
        prev     = ref_pre;
        ref_pre  = 1'($urandom_range(0, 1));
        path_smp = flip ? ~prev : prev;
    endtask

    function automatic bit flip_at(input int mode, input int arg, input int i);
        case (mode)
            1: return (i % 3) == 0;
            2: return 1'b1;
            3: return i < arg;
            default: return 1'b0;
        endcase
    endfunction

    // Driver: runs one window and pushes the expected result
    task automatic run_step(input int len, input int mode, input int arg, input bit inject);
        int cnt = 0;
        int idx;
        idx = int'(cur_step);
        @(negedge clk);
        win_len    = WIN_W'(len);
        step_start = 1'b1;
        drive_cycle(1'b0);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            step_start = inject && (i == 5);
            if (i == 1) chk(busy == 1'b1, "R2 busy in window", int'(busy), 1);
            drive_cycle(flip_at(mode, arg, i));
            cnt += flip_at(mode, arg, i) ? 1 : 0;
        end
        if (cnt > MAXC) cnt = MAXC;
        exp_hist[idx] = cnt;
        exp_q.push_back(cnt);
        idx_q.push_back(idx);
        @(negedge clk);
        step_start = 1'b0;
        chk(step_done == 1'b1, "R4 done timing", int'(step_done), 1);
        chk(busy == 1'b0, "R4 busy drop", int'(busy), 0);
        @(negedge clk);
        chk(int'(cur_step) == idx + 1, "R5 step advance", int'(cur_step), idx + 1);
    endtask

    // Monitor: compares each closed window against the scoreboard
    always @(negedge clk) begin
        if (!rst && step_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected step_done", 1, 0);
            end else begin
                int e, ix;
                e  = exp_q.pop_front();
                ix = idx_q.pop_front();
                chk(int'(last_count) == e, "R2/R3 window count", int'(last_count), e);
                chk(int'(cur_step) == ix, "R4 index at done", int'(cur_step), ix);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; sweep_clr = 1'b0; step_start = 1'b0; ref_pre = 1'b0;
        path_smp = 1'b0; win_len = '0; threshold = CNT_W'(THR); rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(busy == 0 && step_done == 0, "R1 idle", int'(busy), 0);
        chk(cur_step == 0 && !sweep_full, "R1 step zero", int'(cur_step), 0);
        chk(first_fail_vld == 0, "R1 no fail", int'(first_fail_vld), 0);

        run_step(20, 0, 0, 1'b0);   // step 0: clean path
        run_step(36, 1, 0, 1'b0);   // step 1: count equals threshold
        chk(first_fail_vld == 0, "R7 equal no trigger", int'(first_fail_vld), 0);
        run_step(100, 2, 0, 1'b0);  // step 2: saturates
        chk(first_fail_vld == 1, "R7 trigger", int'(first_fail_vld), 1);
        chk(int'(first_fail_idx) == 2, "R7 index", int'(first_fail_idx), 2);
        run_step(40, 3, 20, 1'b1);  // step 3: extra start mid window (R6)
        chk(int'(first_fail_idx) == 2, "R7 held", int'(first_fail_idx), 2);

        // R6: zero-length window refused
        @(negedge clk); win_len = '0; step_start = 1'b1;
        @(negedge clk); step_start = 1'b0;
        chk(busy == 0, "R6 zero length", int'(busy), 0);
        chk(int'(cur_step) == 4, "R6 step unchanged", int'(cur_step), 4);

        for (int s = 4; s < STEPS; s++) run_step(5, 3, s - 3, 1'b0);
        chk(sweep_full == 1, "R9 full", int'(sweep_full), 1);

        // R9: start refused when full
        @(negedge clk); win_len = WIN_W'(5); step_start = 1'b1;
        @(negedge clk); step_start = 1'b0;
        chk(busy == 0, "R9 start refused", int'(busy), 0);
        repeat (8) @(negedge clk);
        chk(int'(cur_step) == STEPS, "R9 index held", int'(cur_step), STEPS);

        // R5: read back every slot
        for (int a = 0; a < STEPS; a++) begin
            @(negedge clk); rd_addr = IDX_W'(a);
            @(negedge clk);
            chk(int'(rd_data) == exp_hist[a], "R5 readback", int'(rd_data), exp_hist[a]);
        end

        // R8: sweep clear
        @(negedge clk); sweep_clr = 1'b1;
        @(negedge clk); sweep_clr = 1'b0;
        chk(cur_step == 0 && !sweep_full, "R8 index reset", int'(cur_step), 0);
        chk(first_fail_vld == 0, "R8 fail cleared", int'(first_fail_vld), 0);
        rd_addr = IDX_W'(2);
        @(negedge clk);
        chk(int'(rd_data) == exp_hist[2], "R8 contents kept", int'(rd_data), exp_hist[2]);

        // R8: abandon an open window
        win_len = WIN_W'(50); step_start = 1'b1;
        @(negedge clk); step_start = 1'b0;
        repeat (10) @(negedge clk);
        sweep_clr = 1'b1;
        @(negedge clk); sweep_clr = 1'b0;
        chk(busy == 0, "R8 abort", int'(busy), 0);
        repeat (60) @(negedge clk);
        chk(int'(cur_step) == 0, "R8 no write after abort", int'(cur_step), 0);
        chk(exp_q.size() == 0, "R4 all windows seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule